// File: doc/BRIEF.md
# Coprocessor Interrupt Control/Status Register

This block is one 16-bit control and status word for an audio coprocessor. It keeps three interrupt pending flags: one for the coprocessor itself, one for the auxiliary-memory DMA engine and one for the audio DMA engine. Each flag has its own enable bit. The word also holds a halt control, a host-signal control bit, and two positions that always read zero: a reset strobe and a DMA status position. Hardware raises a flag with a one-cycle pulse on that source's event input. Software reads the whole word at any time. Software writes the whole word in one cycle, and a 1 written to a pending position clears that flag.

A single registered interrupt line goes to the system interrupt controller. It is high when at least one source is both pending and enabled. The coprocessor core and the DMA engines are outside this block and only drive the event pulses.

Top module: `aco_irq_csr`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_data` reads 0x0004 (halt, bit 2, set; every other bit clear) and `irq_out` is 0.
- R2: A pulse on `cop_evt`, `aux_evt` or `aud_evt` sets the pending bit at position 7, 5 or 3 respectively, and the bit reads 1 from the next cycle on.
- R3: A write with a 1 at a pending position clears that flag from the next cycle on. A write with a 0 there leaves the flag unchanged.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A write stores bit 1 (host signal), bit 2 (halt) and the enable bits at positions 8 (coprocessor), 6 (auxiliary DMA) and 4 (audio DMA) from the written data.
- R6: Bit 0 (reset strobe), bit 9 (DMA status) and bits 15..10 always read 0, whatever was written.
- R7: `irq_out` equals, one cycle later, the OR over the three sources of (pending bit AND its enable bit) as they appear on `rd_data`.
- R8: Without a write, the control bits (1, 2, 4, 6, 8) keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register contents |
| cop_evt | input | 1 | Coprocessor interrupt event pulse |
| aux_evt | input | 1 | Auxiliary-memory DMA completion pulse |
| aud_evt | input | 1 | Audio DMA interrupt pulse |
| irq_out | output | 1 | Combined, registered interrupt request |

## Verification
The main check is a full sweep of the eight enable combinations against the eight pending combinations. Each combination is loaded by a write, raised by event pulses, and then the interrupt line is observed one cycle later. This shows that every source is gated only by its own enable bit and that the line lags its cause by exactly one cycle.

Separate patterns cover the following cases:
- A single event per source, which checks that each input maps to its own bit position.
- Clearing writes with one-hot and zero data, which separate write-1-to-clear from plain storage.
- An event coinciding with its clearing write, which checks that the set wins.
- An all-ones write, which shows the reserved, reset-strobe and status positions staying zero.

// File: rtl/aco_csr_pkg.sv
package aco_csr_pkg;
    localparam int CSR_W  = 16;
    localparam int NSRC   = 3;
    localparam int B_RST  = 0;
    localparam int B_HOST = 1;
    localparam int B_HALT = 2;
    localparam int B_DMAS = 9;

    // Source index: 0 coprocessor, 1 auxiliary DMA, 2 audio DMA
    function automatic int pend_bit(input int s);
        return 7 - 2 * s;
    endfunction

    function automatic int mask_bit(input int s);
        return 8 - 2 * s;
    endfunction

    typedef struct packed {
        logic            host;
        logic            halt;
        logic [NSRC-1:0] en;
    } ctrl_t;

    function automatic logic [CSR_W-1:0] pack_word(input ctrl_t c, input logic [NSRC-1:0] p);
        logic [CSR_W-1:0] w;
        w         = '0;
        w[B_HOST] = c.host;
        w[B_HALT] = c.halt;
        for (int s = 0; s < NSRC; s++) begin
            w[pend_bit(s)] = p[s];
            w[mask_bit(s)] = c.en[s];
        end
        return w;
    endfunction
endpackage

// File: rtl/aco_pend_flag.sv
module aco_pend_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;   // hardware set has priority
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/aco_ctrl_reg.sv
module aco_ctrl_reg
    import aco_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output ctrl_t            ctrl_o
);
    ctrl_t nxt;

    always_comb begin
        nxt.host = wr_data[B_HOST];
        nxt.halt = wr_data[B_HALT];
        for (int s = 0; s < NSRC; s++) begin
            nxt.en[s] = wr_data[mask_bit(s)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o.host <= 1'b0;
            ctrl_o.halt <= 1'b1;
            ctrl_o.en   <= '0;
        end else if (wr_en) begin
            ctrl_o <= nxt;
        end
    end
endmodule

// File: rtl/aco_irq_merge.sv
module aco_irq_merge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    output logic         irq_o
);
    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(pend & en);
    end
endmodule

// File: rtl/aco_irq_csr.sv
module aco_irq_csr
    import aco_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] rd_data,
    input  logic             cop_evt,
    input  logic             aux_evt,
    input  logic             aud_evt,
    output logic             irq_out
);
    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] pend;
    ctrl_t           ctrl;

    assign evt = {aud_evt, aux_evt, cop_evt};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        aco_pend_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt[s]),
            .clr_i (wr_en & wr_data[pend_bit(s)]),
            .q     (pend[s])
        );
    end

    aco_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_o  (ctrl)
    );

    aco_irq_merge #(.N(NSRC)) u_merge (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend),
        .en    (ctrl.en),
        .irq_o (irq_out)
    );

    assign rd_data = pack_word(ctrl, pend);
endmodule

// File: rtl/aco_csr_chk.sv
module aco_csr_chk
    import aco_csr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CSR_W-1:0] wr_data,
    input logic [CSR_W-1:0] rd_data,
    input logic             cop_evt,
    input logic             aux_evt,
    input logic             aud_evt,
    input logic             irq_out
);
    localparam int PC = pend_bit(0);
    localparam int PX = pend_bit(1);
    localparam int PA = pend_bit(2);
    localparam int MC = mask_bit(0);
    localparam int MX = mask_bit(1);
    localparam int MA = mask_bit(2);

    logic any_act;
    assign any_act = (rd_data[PC] & rd_data[MC]) | (rd_data[PX] & rd_data[MX]) |
                     (rd_data[PA] & rd_data[MA]);

    p_reset_val_r1: assert property (@(posedge clk)
        rst |=> (rd_data == 16'h0004 && !irq_out));

    p_cop_set_r2: assert property (@(posedge clk) disable iff (rst)
        cop_evt |=> rd_data[PC]);
    p_aux_set_r2: assert property (@(posedge clk) disable iff (rst)
        aux_evt |=> rd_data[PX]);
    p_aud_set_r2: assert property (@(posedge clk) disable iff (rst)
        aud_evt |=> rd_data[PA]);

    p_cop_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[PC] && !cop_evt) |=> !rd_data[PC]);
    p_aud_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[PA] && !aud_evt) |=> !rd_data[PA]);
    p_aux_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!aux_evt && !(wr_en && wr_data[PX])) |=> $stable(rd_data[PX]));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (cop_evt && wr_en && wr_data[PC]) |=> rd_data[PC]);

    p_ctrl_write_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[B_HOST] == $past(wr_data[B_HOST]) &&
                   rd_data[B_HALT] == $past(wr_data[B_HALT]) &&
                   rd_data[MC] == $past(wr_data[MC]) &&
                   rd_data[MX] == $past(wr_data[MX]) &&
                   rd_data[MA] == $past(wr_data[MA])));

    p_zero_bits_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (!rd_data[B_RST] && !rd_data[B_DMAS] && rd_data[15:10] == 6'd0));

    p_irq_lag_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(any_act)));

    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data & 16'h0156));
endmodule

bind aco_irq_csr aco_csr_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .cop_evt (cop_evt),
    .aux_evt (aux_evt),
    .aud_evt (aud_evt),
    .irq_out (irq_out)
);

// File: tb/tb_aco_irq_csr.sv
module tb_aco_irq_csr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        cop_evt = 1'b0;
    logic        aux_evt = 1'b0;
    logic        aud_evt = 1'b0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state: index 0 coprocessor, 1 aux DMA, 2 audio DMA
    bit       m_host;
    bit       m_halt;
    bit [2:0] m_en;
    bit [2:0] m_pend;
    bit       m_irq;

    always #2 clk = ~clk;   // 250 MHz

    aco_irq_csr dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cop_evt(cop_evt), .aux_evt(aux_evt), .aud_evt(aud_evt), .irq_out(irq_out)
    );

    function automatic logic [15:0] exp_word();
        logic [15:0] w;
        w = 16'(m_host) * 16'd2 + 16'(m_halt) * 16'd4;
        for (int s = 0; s < 3; s++) begin
            w = w + 16'(m_pend[s]) * (16'd1 << (7 - 2 * s))
                  + 16'(m_en[s])   * (16'd1 << (8 - 2 * s));
        end
        return w;
    endfunction

    task automatic check(input string tag);
        logic [15:0] ew;
        ew = exp_word();
        n_chk++;
        if (rd_data !== ew || irq_out !== m_irq) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     tag, rd_data, irq_out, ew, m_irq);
        end
    endtask

    // called at a negative edge; returns at the next negative edge after checking
    task automatic step(input bit we, input logic [15:0] d, input bit [2:0] ev, input string tag);
        bit [2:0] clr;
        wr_en   = we;
        wr_data = d;
        cop_evt = ev[0];
        aux_evt = ev[1];
        aud_evt = ev[2];
        @(posedge clk);
        m_irq = |(m_pend & m_en);
        clr = we ? {d[3], d[5], d[7]} : 3'b000;
        m_pend = (m_pend & ~clr) | ev;
        if (we) begin
            m_host = d[1];
            m_halt = d[2];
            m_en   = {d[4], d[6], d[8]};
        end
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0000;
        cop_evt = 1'b0; aux_evt = 1'b0; aud_evt = 1'b0;
        check(tag);
    endtask

    function automatic logic [15:0] mask_word(input bit [2:0] m);
        logic [15:0] w;
        w = 16'h00A8;   // clear all pending bits
        for (int s = 0; s < 3; s++) begin
            if (m[s]) w = w | (16'd1 << (8 - 2 * s));
        end
        return w;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_host = 0; m_halt = 1; m_en = 0; m_pend = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        check("R1 reset held");
        rst = 1'b0;
        check("R1 after reset");

        // R2: each event to its own bit, none enabled
        step(0, 16'h0000, 3'b001, "R2 cop event bit7");
        step(0, 16'h0000, 3'b010, "R2 aux event bit5");
        step(0, 16'h0000, 3'b100, "R2 aud event bit3");
        // R3: write 0 to pending leaves flags, halt kept by writing it
        step(1, 16'h0004, 3'b000, "R3 zero write keeps pending");
        step(1, 16'h0024, 3'b000, "R3 clear aux only");
        step(1, 16'h008C, 3'b000, "R3 clear cop and aud");
        // R4: set wins over clear
        step(1, 16'h0084, 3'b001, "R4 set wins cop");
        step(1, 16'h0008, 3'b100, "R4 set wins aud");
        // R6: all-ones write; zero bits stay zero, pending cleared, controls set
        step(1, 16'hFFFF, 3'b000, "R6 all-ones write");
        step(0, 16'h0000, 3'b000, "R7 irq after all-ones");
        // R8: hold without writes, events still seen
        step(0, 16'h0000, 3'b010, "R8 control hold with event");
        step(0, 16'h0000, 3'b000, "R8 control hold idle");
        // R5: control writes
        step(1, 16'h00A2, 3'b000, "R5 host set halt clear");
        step(1, 16'h0000, 3'b000, "R5 all controls clear");

        // R7 sweep over enables x pending
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
                step(1, mask_word(3'(m)), 3'b000, "R5 mask load");
                step(0, 16'h0000, 3'(p), "R2 sweep pending");
                step(0, 16'h0000, 3'b000, "R7 sweep irq");
            end
        end
        step(1, 16'h00A8, 3'b000, "R3 final clear");
        step(0, 16'h0000, 3'b000, "R7 irq drops");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule